// File: doc/BRIEF.md
# I2C SCL Clock Timing Generator

This block produces the serial clock of an I2C master. It turns a peripheral clock into an SCL waveform with a programmable divider. It drives SCL only through an open-drain pull-down enable (`scl_oe` high pulls the line low) and reads the line level back on `scl_in`. Reading the line lets it wait for a slow rising edge, or for a slave that stretches the clock, before it times the high phase. Two strobes mark the start of each low phase and each high counted phase. These strobes let a neighbouring shifter or a START/STOP sequencer align its work to SCL.

One count field sets both phase lengths, in peripheral clock cycles. The mode bits then fix the high:low ratio:
- standard mode gives 1:1;
- fast mode gives 1:2;
- fast mode with the duty bit set gives 9:16.

A rise-time allowance is taken off the high count. When the line takes that long to rise, the released time matches the programmed high length. The block checks the configuration against the legal input-frequency range for the selected mode. It refuses to clock when the configuration is illegal. Deasserting the enable stops the block at once.

Top module: `scl_timer`

## Requirements
- R1: After reset, `scl_oe`, `high_start` and `low_start` are 0, and `bus_idle` is 1.
- R2: Standard mode (`clk_ctl[15]`=0): `scl_oe` stays high for C cycles per low phase, and the high count is C cycles. C is `clk_ctl[11:0]`.
- R3: Fast mode with duty clear (`clk_ctl[15]`=1, `clk_ctl[14]`=0): the low phase is 2*C cycles and the high count is C cycles.
- R4: Fast mode with duty set (`clk_ctl[15]`=1, `clk_ctl[14]`=1): the low phase is 16*C cycles and the high count is 9*C cycles.
- R5: Bits 13:12 of `clk_ctl` have no effect on timing. In standard mode, bit 14 has no effect.
- R6: After `scl_oe` falls, the high count starts only in the cycle after `scl_in` is first sampled high. A line held low delays it without limit. The released time is W + hcount, where W is the number of cycles spent waiting for `scl_in` to be sampled high.
- R7: hcount is the high length minus `rise_max` when that difference is at least 1, and 1 otherwise.
- R8: `cfg_err` is 1 when `freq_mhz` lies outside 2..46 in standard mode or outside 6..46 in fast mode. While `cfg_err` is 1, `scl_oe` is 0 and `bus_idle` is 1.
- R9: A count field of zero sets `cfg_err` and keeps SCL released.
- R10: When `en` is 0 at a clock edge, `scl_oe` is 0 and `bus_idle` is 1 after that edge.
- R11: `low_start` is 1 exactly in the first cycle of each `scl_oe` high run. `high_start` is 1 exactly in the first cycle of the high count. Each fires once per phase, and the two never fire together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable |
| freq_mhz | input | 6 | Peripheral clock frequency in MHz |
| clk_ctl | input | 16 | [11:0] count, [14] duty, [15] fast mode |
| rise_max | input | 6 | Rise-time allowance in clock cycles |
| scl_in | input | 1 | Sensed SCL level (synchronous to clk) |
| scl_oe | output | 1 | 1 pulls SCL low |
| high_start | output | 1 | First cycle of the high count |
| low_start | output | 1 | First cycle of a low phase |
| bus_idle | output | 1 | Generator stopped, SCL released |
| cfg_err | output | 1 | Configuration out of range |

## Verification
The case that is hardest to reach from the ports is the wait after release. Here the sensed line lags `scl_in` and the rise-time allowance interact. The released time depends on how long the line stays low, on the high length, and on `rise_max`, including the clamp at one cycle. The bench models the line as a pull-up with a programmable delay that follows `scl_oe`. It then sweeps three kinds of case: delays equal to the allowance, long stretches, and allowances larger than the high length. Random configurations across all three ratios are mixed with directed checks at each frequency-range boundary.

// File: rtl/scl_timer.sv
module scl_timer #(
  parameter int CW       = 12,
  parameter int FW       = 6,
  parameter int RW       = 6,
  parameter int STD_MIN  = 2,
  parameter int FAST_MIN = 6,
  parameter int FREQ_MAX = 46
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [FW-1:0] freq_mhz,
  input  logic [15:0]   clk_ctl,
  input  logic [RW-1:0] rise_max,
  input  logic          scl_in,
  output logic          scl_oe,
  output logic          high_start,
  output logic          low_start,
  output logic          bus_idle,
  output logic          cfg_err
);
  localparam int LW = CW + 5;

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_WAIT, S_HIGH} st_t;

  st_t           st;
  logic [LW-1:0] cnt;
  logic          fast, duty;
  logic [LW-1:0] base, hi_len, lo_len, hcnt, rise_w;
  int            fmin;

  assign fast   = clk_ctl[15];
  assign duty   = clk_ctl[14];
  assign base   = LW'(clk_ctl[CW-1:0]);
  assign rise_w = LW'(rise_max);
  assign hi_len = (fast && duty) ? (base << 3) + base : base;
  assign lo_len = !fast ? base : (duty ? base << 4 : base << 1);
  assign hcnt   = (hi_len > rise_w) ? hi_len - rise_w : LW'(1);
  assign fmin   = fast ? FAST_MIN : STD_MIN;

  assign cfg_err  = (clk_ctl[CW-1:0] == '0) ||
                    (int'(freq_mhz) < fmin) || (int'(freq_mhz) > FREQ_MAX);
  assign scl_oe   = (st == S_LOW);
  assign bus_idle = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      high_start <= 1'b0;
      low_start  <= 1'b0;
    end else begin
      high_start <= 1'b0;
      low_start  <= 1'b0;
      if (!en || cfg_err) begin
        st  <= S_IDLE;
        cnt <= '0;
      end else begin
        case (st)
          S_IDLE: begin
            st        <= S_LOW;
            cnt       <= lo_len - LW'(1);
            low_start <= 1'b1;
          end
          S_LOW: begin
            if (cnt == '0) st <= S_WAIT;
            else           cnt <= cnt - LW'(1);
          end
          S_WAIT: begin
            if (scl_in) begin
              st         <= S_HIGH;
              cnt        <= hcnt - LW'(1);
              high_start <= 1'b1;
            end
          end
          default: begin
            if (cnt == '0) begin
              st        <= S_LOW;
              cnt       <= lo_len - LW'(1);
              low_start <= 1'b1;
            end else begin
              cnt <= cnt - LW'(1);
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/scl_timer_chk.sv
module scl_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic scl_in,
  input logic scl_oe,
  input logic high_start,
  input logic low_start,
  input logic bus_idle,
  input logic cfg_err
);
  a_r10_release_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_oe && bus_idle));

  a_r8_release_on_cfg_err: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> (!scl_oe && bus_idle));

  a_r11_low_strobe_on_pull: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> low_start);

  a_r11_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({high_start, low_start}));

  a_r6_high_after_sensed: assert property (@(posedge clk) disable iff (!rst_n)
    high_start |-> ($past(scl_in) && !scl_oe));

  a_r8_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    bus_idle |-> !scl_oe);
endmodule

bind scl_timer scl_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .scl_in(scl_in), .scl_oe(scl_oe),
  .high_start(high_start), .low_start(low_start), .bus_idle(bus_idle),
  .cfg_err(cfg_err)
);

// File: tb/test_scl_timer.sv
module test_scl_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [5:0]  freq_mhz = 6'd8;
  logic [15:0] clk_ctl = 16'd4;
  logic [5:0]  rise_max = 6'd0;
  logic        scl_in = 1'b0;
  logic        scl_oe, high_start, low_start, bus_idle, cfg_err;

  int checks = 0;
  int fails = 0;
  int dly = 0;
  int rc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_timer i_scl_timer (
    .clk(clk), .rst_n(rst_n), .en(en), .freq_mhz(freq_mhz), .clk_ctl(clk_ctl),
    .rise_max(rise_max), .scl_in(scl_in), .scl_oe(scl_oe),
    .high_start(high_start), .low_start(low_start), .bus_idle(bus_idle),
    .cfg_err(cfg_err)
  );

  // line model: pulled low by scl_oe, rises dly+1 samples after release
  always @(negedge clk) begin
    if (scl_oe) begin
      rc = 0;
      scl_in = 1'b0;
    end else begin
      rc = rc + 1;
      scl_in = (rc >= dly + 1);
    end
  end

  function automatic int f_hi(bit f, bit d, int c);
    return (f && d) ? 9 * c : c;
  endfunction
  function automatic int f_lo(bit f, bit d, int c);
    return !f ? c : (d ? 16 * c : 2 * c);
  endfunction
  function automatic int f_hcnt(int h, int r);
    return (h > r) ? h - r : 1;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic measure(string req, int lo, int rel, int hidx, int nper);
    int n, ls, hs, hpos;
    n = 0;
    while (!scl_oe && n < 2000) begin @(negedge clk); n++; end
    chk(scl_oe, {req, " start"}, int'(scl_oe), 1);
    for (int p = 0; p < nper; p++) begin
      n = 0; ls = 0;
      while (scl_oe) begin
        if (low_start) ls += (n == 0) ? 1 : 100;
        n++;
        @(negedge clk);
      end
      chk(n == lo, {req, " low length"}, n, lo);
      chk(ls == 1, {req, " R11 low_start"}, ls, 1);
      n = 0; hs = 0; hpos = -1;
      while (!scl_oe && n < 5000) begin
        if (high_start) begin hs++; hpos = n; end
        n++;
        @(negedge clk);
      end
      chk(n == rel, {req, " released length"}, n, rel);
      chk(hs == 1 && hpos == hidx, {req, " R11 high_start pos"}, hpos, hidx);
    end
  endtask

  task automatic stop_run();
    en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_cfg(string req, bit f, bit d, int c, int fq, int r, int dl, int extra);
    int h, l;
    stop_run();
    clk_ctl  = {f, d, 2'(extra), 12'(c)};
    freq_mhz = 6'(fq);
    rise_max = 6'(r);
    dly      = dl;
    h = f_hi(f, d, c);
    l = f_lo(f, d, c);
    en = 1'b1;
    measure(req, l, dl + 1 + f_hcnt(h, r), dl + 1, 2);
  endtask

  task automatic expect_err(string req, bit f, int c, int fq);
    int bad;
    stop_run();
    clk_ctl  = {f, 1'b0, 2'b00, 12'(c)};
    freq_mhz = 6'(fq);
    en = 1'b1;
    bad = 0;
    repeat (12) begin @(negedge clk); if (scl_oe || !bus_idle) bad++; end
    chk(cfg_err == 1'b1, {req, " cfg_err"}, int'(cfg_err), 1);
    chk(bad == 0, {req, " held released"}, bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int f, d, c, fq, r, dl, x;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk(!scl_oe && bus_idle && !high_start && !low_start, "R1 reset in reset",
        int'(scl_oe), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!scl_oe && bus_idle, "R1 reset after release", int'(bus_idle), 1);

    run_cfg("R2 std", 0, 0, 6, 8, 0, 0, 0);
    run_cfg("R3 fast", 1, 0, 5, 10, 0, 0, 0);
    run_cfg("R4 fast duty", 1, 1, 3, 20, 0, 0, 0);
    run_cfg("R5 ignored bits std duty", 0, 1, 7, 8, 0, 0, 3);
    run_cfg("R6 stretch", 0, 0, 5, 8, 3, 40, 0);
    run_cfg("R7 rise matched", 0, 0, 20, 8, 5, 4, 0);
    run_cfg("R7 rise clamp", 0, 0, 2, 8, 10, 0, 0);
    run_cfg("R8 std min ok", 0, 0, 4, 2, 0, 1, 0);
    run_cfg("R8 fast min ok", 1, 0, 4, 6, 0, 1, 0);
    run_cfg("R8 max ok", 1, 1, 1, 46, 2, 2, 0);

    expect_err("R8 std below", 0, 4, 1);
    expect_err("R8 fast below", 1, 4, 5);
    expect_err("R8 above", 0, 4, 47);
    expect_err("R9 zero count", 0, 0, 8);

    // R10: disable in the middle of a low phase
    stop_run();
    clk_ctl = {4'b0000, 12'd20};
    freq_mhz = 6'd8;
    rise_max = 6'd0;
    dly = 0;
    en = 1'b1;
    while (!scl_oe) @(negedge clk);
    repeat (3) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(!scl_oe && bus_idle, "R10 disable mid low", int'(scl_oe), 0);

    for (int i = 0; i < 30; i++) begin
      f  = $urandom_range(1, 0);
      d  = $urandom_range(1, 0);
      c  = $urandom_range(12, 1);
      fq = $urandom_range(46, f ? 6 : 2);
      r  = $urandom_range(15, 0);
      dl = $urandom_range(6, 0);
      x  = $urandom_range(3, 0);
      run_cfg(f ? (d ? "R4 random" : "R3 random") : "R2 random",
              f[0], d[0], c, fq, r, dl, x);
    end

    stop_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule